// File: doc/BRIEF.md
# Audio DMA Channel Register and Interrupt Block

This block holds the programming state of three audio DMA channels (input capture, playback and microphone capture) and the global control and status words, all reached through a 64-byte register window that accepts byte, word and dword accesses. Software starts, stops and resets each channel by writing its control byte. It arms interrupts with enable bits and acknowledges them by writing ones to the status byte. A DMA engine beside the block receives one-cycle pulses for start, stop, reset and restart, and reports progress back through a position-update port and per-channel status-set strobes. The engine fetches descriptors and moves data; this block does neither.

Each channel has a 16-byte slot whose index comes from address bits [5:4]. Bus accesses complete in one cycle with no back-pressure. A write takes effect at the rising edge where `bus_sel` and `bus_wr` are high. Read data is combinational from the address while `bus_sel` is high and `bus_wr` is low, and is zero otherwise. The single level interrupt output is the OR of the three channel requests.

Top module: `adma_csr`

## Requirements
- R1: After reset every channel status reads 0x01 (bit 0 halted), and every other channel register reads 0. Global control reads 0, global status reads 0x100, `irq` is low and no DMA pulse or run output is asserted.
- R2: Channel slot layout at offsets within the slot: descriptor base +0 (dword), current index +4, last-valid index +5, status +6 (byte or word), remaining count +8 (word), prefetch index +10, control +11. A dword read at +4 returns {status[15:0], last[7:0], current[7:0]}. A dword read at +8 returns {control[7:0], prefetch[7:0], count[15:0]}.
- R3: Status bits: 4 FIFO error, 3 buffer complete, 2 last-valid buffer done, 1 current-equals-last, 0 halted. Writing a 1 to bits 4..2 clears them, and writes never change bits 1..0. An engine status-set strobe in the same cycle as a clear leaves the bit set.
- R4: Control stores only its low 5 bits: 4 completion-interrupt enable, 3 FIFO-error enable, 2 last-valid enable, 1 register reset, 0 run. Writing run=1 to a stopped channel copies prefetch into current, advances prefetch by one modulo 32, clears halted and pulses `dma_start`. Writing run=0 sets halted, and pulses `dma_stop` if the channel was running.
- R5: A control write with bit 1 set clears descriptor base, current, last-valid, count and prefetch, sets status to 0x01, keeps control bits 4..2, clears control bits 1..0 and pulses `dma_rst`.
- R6: Writing the last-valid index (low 5 bits stored) while run=1 and halted=1 clears status bits 1..0, copies prefetch into current, advances prefetch by one modulo 32 and pulses `dma_fetch`. In any other state the write only updates the index.
- R7: A channel requests an interrupt when (status bit 2 and control bit 2) or (status bit 3 and control bit 4). FIFO error never requests one. Global status bits 5, 6 and 7 show the requests of channels 0, 1 and 2, and `irq` is their OR.
- R8: A dword write to global control at 0x2C is stored, masked to 6 bits, only when bits 2 and 1 of the data are both zero. Otherwise it is dropped.
- R9: Global status at 0x30 always reads bit 8 as 1. Bits 15, 11, 10 and 0 are set by `glb_evt[3]`, `[2]`, `[1]` and `[0]`, and a written 1 clears them. Bits 17..16 are read-write. All other bits ignore writes.
- R10: Reads that match no register return 0xFFFFFFFF. Writes to current index, prefetch index and count are ignored.
- R11: A dword write to the descriptor base stores the data with bits 1..0 forced to zero.
- R12: `eng_we` loads current, prefetch and count of channel `eng_ch` from `eng_cur`, `eng_pre` and `eng_cnt`. A start, restart or reset in the same cycle on the same channel takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address in the window |
| bus_size | input | 2 | 0 byte, 1 word, 2 dword |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, combinational |
| eng_we | input | 1 | Engine position update strobe |
| eng_ch | input | 2 | Channel of the position update |
| eng_cur | input | 5 | New current index |
| eng_pre | input | 5 | New prefetch index |
| eng_cnt | input | 16 | New remaining count |
| eng_sts_set | input | 15 | Per-channel status set strobes, 5 bits per channel |
| glb_evt | input | 4 | Sets global status bits 0, 10, 11, 15 |
| dma_run | output | 3 | Run bit of each channel |
| dma_start | output | 3 | One-cycle start pulse per channel |
| dma_stop | output | 3 | One-cycle stop pulse per channel |
| dma_rst | output | 3 | One-cycle register-reset pulse per channel |
| dma_fetch | output | 3 | One-cycle restart/fetch pulse per channel |
| irq | output | 1 | Level interrupt |

## Verification
Assertions check every cycle that write-one-to-clear bits fall after an acknowledge, that read-only status bits survive status writes, and that a register reset keeps the enables while clearing the rest. On every cycle they also check the index moves of start and restart, that a rejected global control write leaves the register unchanged, and that `irq` tracks global status bits 7..5. Only the bench's scenarios can show the packed dword layouts, the all-ones answer for unmapped reads, and that a FIFO error alone raises no interrupt. The same holds for an engine set winning over a same-cycle clear and the exact cycle in which each DMA pulse appears.

// File: rtl/adma_pkg.sv
`timescale 1ns/1ps
package adma_pkg;
  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_W = 2'd1, SZ_D = 2'd2} acc_sz_e;

  localparam int ST_W = 5;
  localparam int CT_W = 5;

  // status bit positions
  localparam int ST_HALT = 0;
  localparam int ST_CELV = 1;
  localparam int ST_LVB  = 2;
  localparam int ST_BC   = 3;
  localparam int ST_FIFO = 4;
  localparam logic [ST_W-1:0] ST_W1C_MASK = 5'b11100;
  localparam logic [ST_W-1:0] ST_RST_VAL  = 5'b00001;

  // control bit positions
  localparam int CT_RUN  = 0;
  localparam int CT_RST  = 1;
  localparam int CT_LVBE = 2;
  localparam int CT_FIFE = 3;
  localparam int CT_BCE  = 4;
  localparam logic [CT_W-1:0] CT_KEEP_MASK = 5'b11100;

  // offsets inside a channel slot
  localparam logic [3:0] OF_BASE = 4'h0;
  localparam logic [3:0] OF_CUR  = 4'h4;
  localparam logic [3:0] OF_LAST = 4'h5;
  localparam logic [3:0] OF_STS  = 4'h6;
  localparam logic [3:0] OF_CNT  = 4'h8;
  localparam logic [3:0] OF_PRE  = 4'hA;
  localparam logic [3:0] OF_CTL  = 4'hB;

  // global registers
  localparam logic [5:0] A_GCTL = 6'h2C;
  localparam logic [5:0] A_GSTS = 6'h30;
  localparam int GC_W = 6;
  localparam int GS_READY_BIT = 8;
  localparam int GS_IRQ_LSB   = 5;
endpackage

// File: rtl/adma_chan.sv
`timescale 1ns/1ps
module adma_chan
  import adma_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_base,
  input  logic             wr_last,
  input  logic             wr_sts,
  input  logic             wr_ctl,
  input  logic [31:0]      wdata,
  input  logic             pos_we,
  input  logic [IDX_W-1:0] pos_cur,
  input  logic [IDX_W-1:0] pos_pre,
  input  logic [CNT_W-1:0] pos_cnt,
  input  logic [ST_W-1:0]  sts_set,
  output logic [31:0]      base_q,
  output logic [IDX_W-1:0] cur_q,
  output logic [IDX_W-1:0] last_q,
  output logic [ST_W-1:0]  sts_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [IDX_W-1:0] pre_q,
  output logic [CT_W-1:0]  ctl_q,
  output logic             irq_req,
  output logic             start_p,
  output logic             stop_p,
  output logic             rst_p,
  output logic             fetch_p
);
  logic [31:0]      n_base;
  logic [IDX_W-1:0] n_cur, n_last, n_pre;
  logic [ST_W-1:0]  n_sts;
  logic [CNT_W-1:0] n_cnt;
  logic [CT_W-1:0]  n_ctl;
  logic             n_start, n_stop, n_rst, n_fetch;

  always_comb begin
    n_base  = base_q;
    n_cur   = cur_q;
    n_last  = last_q;
    n_pre   = pre_q;
    n_cnt   = cnt_q;
    n_ctl   = ctl_q;
    n_sts   = sts_q;
    n_start = 1'b0;
    n_stop  = 1'b0;
    n_rst   = 1'b0;
    n_fetch = 1'b0;

    if (pos_we) begin
      n_cur = pos_cur;
      n_pre = pos_pre;
      n_cnt = pos_cnt;
    end

    if (wr_sts) n_sts = n_sts & ~(wdata[ST_W-1:0] & ST_W1C_MASK);
    n_sts = n_sts | sts_set;

    if (wr_base) n_base = {wdata[31:2], 2'b00};

    if (wr_last) begin
      n_last = wdata[IDX_W-1:0];
      if (ctl_q[CT_RUN] && sts_q[ST_HALT]) begin
        n_sts[ST_HALT] = 1'b0;
        n_sts[ST_CELV] = 1'b0;
        n_cur          = pre_q;
        n_pre          = pre_q + 1'b1;
        n_fetch        = 1'b1;
      end
    end

    if (wr_ctl) begin
      if (wdata[CT_RST]) begin
        n_base = '0;
        n_cur  = '0;
        n_last = '0;
        n_pre  = '0;
        n_cnt  = '0;
        n_sts  = ST_RST_VAL;
        n_ctl  = ctl_q & CT_KEEP_MASK;
        n_rst  = 1'b1;
      end else begin
        n_ctl = wdata[CT_W-1:0];
        if (!wdata[CT_RUN]) begin
          n_sts[ST_HALT] = 1'b1;
          n_stop         = ctl_q[CT_RUN];
        end else if (!ctl_q[CT_RUN]) begin
          n_cur          = pre_q;
          n_pre          = pre_q + 1'b1;
          n_sts[ST_HALT] = 1'b0;
          n_start        = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      cur_q   <= '0;
      last_q  <= '0;
      pre_q   <= '0;
      cnt_q   <= '0;
      ctl_q   <= '0;
      sts_q   <= ST_RST_VAL;
      start_p <= 1'b0;
      stop_p  <= 1'b0;
      rst_p   <= 1'b0;
      fetch_p <= 1'b0;
    end else begin
      base_q  <= n_base;
      cur_q   <= n_cur;
      last_q  <= n_last;
      pre_q   <= n_pre;
      cnt_q   <= n_cnt;
      ctl_q   <= n_ctl;
      sts_q   <= n_sts;
      start_p <= n_start;
      stop_p  <= n_stop;
      rst_p   <= n_rst;
      fetch_p <= n_fetch;
    end
  end

  assign irq_req = (sts_q[ST_LVB] & ctl_q[CT_LVBE]) | (sts_q[ST_BC] & ctl_q[CT_BCE]);

  // R3: acknowledged completion bit drops unless re-set by the engine
  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && wdata[ST_BC] && !sts_set[ST_BC]) |=> !sts_q[ST_BC]);

  // R3: status writes leave the read-only bits alone
  p_ro_bits_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && sts_set[1:0] == 2'b00) |=> sts_q[1:0] == $past(sts_q[1:0]));

  // R5: register reset keeps the enables and clears the rest
  p_reset_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && wdata[CT_RST]) |=>
      (ctl_q[4:2] == $past(ctl_q[4:2]) && ctl_q[1:0] == 2'b00 &&
       sts_q == ST_RST_VAL && cur_q == '0 && pre_q == '0 && rst_p));

  // R6: restart of a halted running channel
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_last && ctl_q[CT_RUN] && sts_q[ST_HALT]) |=>
      (fetch_p && !sts_q[ST_HALT] && !sts_q[ST_CELV] &&
       cur_q == $past(pre_q) && pre_q == IDX_W'($past(pre_q) + 1'b1)));

  // R4: start clears halted and pulses start
  p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !wdata[CT_RST] && wdata[CT_RUN] && !ctl_q[CT_RUN]) |=>
      (start_p && !sts_q[ST_HALT] && cur_q == $past(pre_q)));

  // R4: clearing run halts the channel
  p_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !wdata[CT_RST] && !wdata[CT_RUN]) |=> sts_q[ST_HALT]);
endmodule

// File: rtl/adma_glob.sv
`timescale 1ns/1ps
module adma_glob
  import adma_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int EVT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctl,
  input  logic              wr_sts,
  input  logic [31:0]       wdata,
  input  logic [EVT_W-1:0]  evt,
  input  logic [NUM_CH-1:0] chan_irq,
  output logic [31:0]       gctl_rd,
  output logic [31:0]       gsts_rd
);
  localparam int W1C_POS [EVT_W] = '{0, 10, 11, 15};
  localparam int RW_LSB = 16;
  localparam int RW_W   = 2;

  logic [GC_W-1:0]  gctl_q;
  logic [RW_W-1:0]  rw_q;
  logic [EVT_W-1:0] w1c_q, n_w1c;
  logic             accept_ctl;
  logic             unused_wdata;

  assign accept_ctl   = wr_ctl && !wdata[2] && !wdata[1];
  assign unused_wdata = ^{wdata[31:RW_LSB+RW_W], wdata[14:12], wdata[9:6]};

  always_comb begin
    for (int i = 0; i < EVT_W; i++) begin
      n_w1c[i] = (w1c_q[i] & ~(wr_sts & wdata[W1C_POS[i]])) | evt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gctl_q <= '0;
      rw_q   <= '0;
      w1c_q  <= '0;
    end else begin
      if (accept_ctl) gctl_q <= wdata[GC_W-1:0];
      if (wr_sts) rw_q <= wdata[RW_LSB +: RW_W];
      w1c_q <= n_w1c;
    end
  end

  always_comb begin
    gsts_rd = '0;
    gsts_rd[RW_LSB +: RW_W] = rw_q;
    for (int i = 0; i < EVT_W; i++) gsts_rd[W1C_POS[i]] = w1c_q[i];
    gsts_rd[GS_READY_BIT] = 1'b1;
    gsts_rd[GS_IRQ_LSB +: NUM_CH] = chan_irq;
  end

  assign gctl_rd = 32'(gctl_q);

  // R8: a write carrying a reset bit leaves global control unchanged
  p_gctl_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && (wdata[2] || wdata[1])) |=> gctl_q == $past(gctl_q));

  // R9: write-one-to-clear on global status bit 15
  p_gsts_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && wdata[15] && !evt[3]) |=> !gsts_rd[15]);
endmodule

// File: rtl/adma_csr.sv
`timescale 1ns/1ps
module adma_csr
  import adma_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int IDX_W  = 5,
  parameter int CNT_W  = 16,
  parameter int EVT_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_wr,
  input  logic [5:0]             bus_addr,
  input  logic [1:0]             bus_size,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic                   eng_we,
  input  logic [1:0]             eng_ch,
  input  logic [IDX_W-1:0]       eng_cur,
  input  logic [IDX_W-1:0]       eng_pre,
  input  logic [CNT_W-1:0]       eng_cnt,
  input  logic [NUM_CH*ST_W-1:0] eng_sts_set,
  input  logic [EVT_W-1:0]       glb_evt,
  output logic [NUM_CH-1:0]      dma_run,
  output logic [NUM_CH-1:0]      dma_start,
  output logic [NUM_CH-1:0]      dma_stop,
  output logic [NUM_CH-1:0]      dma_rst,
  output logic [NUM_CH-1:0]      dma_fetch,
  output logic                   irq
);
  logic [1:0] ch_sel;
  logic [3:0] off;
  logic       is_gctl, is_gsts, is_glob, do_wr;
  logic [NUM_CH-1:0] req;

  logic [31:0]      base_a [NUM_CH];
  logic [IDX_W-1:0] cur_a  [NUM_CH];
  logic [IDX_W-1:0] last_a [NUM_CH];
  logic [ST_W-1:0]  sts_a  [NUM_CH];
  logic [CNT_W-1:0] cnt_a  [NUM_CH];
  logic [IDX_W-1:0] pre_a  [NUM_CH];
  logic [CT_W-1:0]  ctl_a  [NUM_CH];

  logic [31:0] gctl_rd, gsts_rd, rd_v;

  assign ch_sel  = bus_addr[5:4];
  assign off     = bus_addr[3:0];
  assign is_gctl = (bus_addr == A_GCTL);
  assign is_gsts = (bus_addr == A_GSTS);
  assign is_glob = is_gctl | is_gsts;
  assign do_wr   = bus_sel & bus_wr;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = (ch_sel == 2'(g)) && !is_glob;

    adma_chan #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_base (do_wr && hit && off == OF_BASE && bus_size == SZ_D),
      .wr_last (do_wr && hit && off == OF_LAST && bus_size == SZ_B),
      .wr_sts  (do_wr && hit && off == OF_STS &&
                (bus_size == SZ_B || bus_size == SZ_W)),
      .wr_ctl  (do_wr && hit && off == OF_CTL && bus_size == SZ_B),
      .wdata   (bus_wdata),
      .pos_we  (eng_we && eng_ch == 2'(g)),
      .pos_cur (eng_cur),
      .pos_pre (eng_pre),
      .pos_cnt (eng_cnt),
      .sts_set (eng_sts_set[g*ST_W +: ST_W]),
      .base_q  (base_a[g]),
      .cur_q   (cur_a[g]),
      .last_q  (last_a[g]),
      .sts_q   (sts_a[g]),
      .cnt_q   (cnt_a[g]),
      .pre_q   (pre_a[g]),
      .ctl_q   (ctl_a[g]),
      .irq_req (req[g]),
      .start_p (dma_start[g]),
      .stop_p  (dma_stop[g]),
      .rst_p   (dma_rst[g]),
      .fetch_p (dma_fetch[g])
    );
    assign dma_run[g] = ctl_a[g][CT_RUN];
  end

  adma_glob #(.NUM_CH(NUM_CH), .EVT_W(EVT_W)) u_glob (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctl   (do_wr && is_gctl && bus_size == SZ_D),
    .wr_sts   (do_wr && is_gsts && bus_size == SZ_D),
    .wdata    (bus_wdata),
    .evt      (glb_evt),
    .chan_irq (req),
    .gctl_rd  (gctl_rd),
    .gsts_rd  (gsts_rd)
  );

  assign irq = |req;

  always_comb begin
    rd_v = '1;
    if (is_glob) begin
      if (bus_size == SZ_D) rd_v = is_gctl ? gctl_rd : gsts_rd;
    end else if (int'(ch_sel) < NUM_CH) begin
      case (bus_size)
        SZ_B: begin
          case (off)
            OF_CUR:  rd_v = 32'(cur_a[ch_sel]);
            OF_LAST: rd_v = 32'(last_a[ch_sel]);
            OF_STS:  rd_v = 32'(sts_a[ch_sel]);
            OF_PRE:  rd_v = 32'(pre_a[ch_sel]);
            OF_CTL:  rd_v = 32'(ctl_a[ch_sel]);
            default: rd_v = '1;
          endcase
        end
        SZ_W: begin
          case (off)
            OF_STS:  rd_v = 32'(sts_a[ch_sel]);
            OF_CNT:  rd_v = 32'(cnt_a[ch_sel]);
            default: rd_v = '1;
          endcase
        end
        SZ_D: begin
          case (off)
            OF_BASE: rd_v = base_a[ch_sel];
            OF_CUR:  rd_v = {16'(sts_a[ch_sel]), 8'(last_a[ch_sel]), 8'(cur_a[ch_sel])};
            OF_CNT:  rd_v = {8'(ctl_a[ch_sel]), 8'(pre_a[ch_sel]), 16'(cnt_a[ch_sel])};
            default: rd_v = '1;
          endcase
        end
        default: rd_v = '1;
      endcase
    end
    bus_rdata = (bus_sel && !bus_wr) ? rd_v : '0;
  end

  // R7: interrupt line agrees with the per-channel bits of global status
  p_irq_matches_gsts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (gsts_rd[GS_IRQ_LSB +: NUM_CH] != '0));

  // R4: one bus write can start at most one channel
  p_single_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dma_start));
endmodule

// File: tb/adma_csr_test.sv
`timescale 1ns/1ps
module adma_csr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_we = 1'b0;
  logic [1:0]  eng_ch = '0;
  logic [4:0]  eng_cur = '0, eng_pre = '0;
  logic [15:0] eng_cnt = '0;
  logic [14:0] eng_sts_set = '0;
  logic [3:0]  glb_evt = '0;
  logic [2:0]  dma_run, dma_start, dma_stop, dma_rst, dma_fetch;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  adma_csr uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .eng_we(eng_we), .eng_ch(eng_ch),
    .eng_cur(eng_cur), .eng_pre(eng_pre), .eng_cnt(eng_cnt),
    .eng_sts_set(eng_sts_set), .glb_evt(glb_evt), .dma_run(dma_run),
    .dma_start(dma_start), .dma_stop(dma_stop), .dma_rst(dma_rst),
    .dma_fetch(dma_fetch), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [5:0]  a;
    logic [1:0]  sz;
    logic [31:0] d;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'h06, 2'd1, 32'h0000_0001, 8'd1},   // R1 status halted
    '{1'b0, 6'h04, 2'd2, 32'h0001_0000, 8'd2},   // R2 packed +4
    '{1'b0, 6'h30, 2'd2, 32'h0000_0100, 8'd1},   // R1 global status
    '{1'b0, 6'h2C, 2'd2, 32'h0000_0000, 8'd1},   // R1 global control
    '{1'b1, 6'h00, 2'd2, 32'h1234_5677, 8'd11},  // R11 base write
    '{1'b0, 6'h00, 2'd2, 32'h1234_5674, 8'd11},  // R11 low bits zero
    '{1'b1, 6'h05, 2'd0, 32'h0000_0023, 8'd6},   // R6 last-valid while stopped
    '{1'b0, 6'h05, 2'd0, 32'h0000_0003, 8'd6},   // R6 5-bit store
    '{1'b1, 6'h0B, 2'd0, 32'h0000_001D, 8'd4},   // R4 run
    '{1'b0, 6'h08, 2'd2, 32'h1D01_0000, 8'd4},   // R4 prefetch advanced
    '{1'b0, 6'h04, 2'd2, 32'h0000_0300, 8'd4},   // R4 halted cleared
    '{1'b1, 6'h0B, 2'd0, 32'h0000_001C, 8'd4},   // R4 stop
    '{1'b0, 6'h06, 2'd0, 32'h0000_0001, 8'd4},   // R4 halted set
    '{1'b1, 6'h0B, 2'd0, 32'h0000_001E, 8'd5},   // R5 reset command
    '{1'b0, 6'h08, 2'd2, 32'h1C00_0000, 8'd5},   // R5 enables kept
    '{1'b0, 6'h00, 2'd2, 32'h0000_0000, 8'd5},   // R5 base cleared
    '{1'b0, 6'h04, 2'd2, 32'h0001_0000, 8'd5},   // R5 status 0x01
    '{1'b1, 6'h0A, 2'd0, 32'h0000_0007, 8'd10},  // R10 prefetch write
    '{1'b0, 6'h0A, 2'd0, 32'h0000_0000, 8'd10},  // R10 ignored
    '{1'b0, 6'h3C, 2'd2, 32'hFFFF_FFFF, 8'd10},  // R10 unmapped
    '{1'b1, 6'h2C, 2'd2, 32'h0000_003F, 8'd8},   // R8 rejected
    '{1'b0, 6'h2C, 2'd2, 32'h0000_0000, 8'd8},   // R8
    '{1'b1, 6'h2C, 2'd2, 32'h0000_00F9, 8'd8},   // R8 accepted
    '{1'b0, 6'h2C, 2'd2, 32'h0000_0039, 8'd8},   // R8 masked
    '{1'b1, 6'h30, 2'd2, 32'h0003_FFFF, 8'd9},   // R9 write all ones
    '{1'b0, 6'h30, 2'd2, 32'h0003_0100, 8'd9},   // R9
    '{1'b1, 6'h30, 2'd2, 32'h0000_0000, 8'd9},   // R9
    '{1'b0, 6'h30, 2'd2, 32'h0000_0100, 8'd9},   // R9
    '{1'b1, 6'h1B, 2'd0, 32'h0000_0001, 8'd4},   // R4 channel 1 run
    '{1'b0, 6'h18, 2'd2, 32'h0101_0000, 8'd2},   // R2 packed +8
    '{1'b0, 6'h26, 2'd1, 32'h0000_0001, 8'd2}    // R2 channel 2 slot
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    eng_we = 1'b0; eng_sts_set = '0; glb_evt = '0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [1:0] sz, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
    cycle();
  endtask

  task automatic rd(input logic [5:0] a, input logic [1:0] sz, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = sz;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #200us;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: outputs after reset
    chk(32'(irq), 32'h0, "R1 irq");
    chk(32'({dma_run, dma_start, dma_stop, dma_rst, dma_fetch}), 32'h0, "R1 dma outputs");

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) begin
        wr(VECS[i].a, VECS[i].sz, VECS[i].d);
      end else begin
        rd(VECS[i].a, VECS[i].sz, v);
        chk(v, VECS[i].d, $sformatf("R%0d vector %0d", VECS[i].req, i));
      end
    end

    // R7: channel 1 halts with last-valid done but its enable is clear
    eng_sts_set[5 +: 5] = 5'b00111;
    cycle();
    chk(32'(irq), 32'h0, "R7 no irq without enable");
    rd(6'h16, 2'd1, v); chk(v, 32'h7, "R3 engine set status");

    // R6: restart by last-valid write
    wr(6'h15, 2'd0, 32'h5);
    chk(32'(dma_fetch), 32'h2, "R6 fetch pulse");
    rd(6'h14, 2'd2, v); chk(v, 32'h0004_0501, "R6 indices after restart");

    // R7: enable last-valid interrupt on running channel 1
    wr(6'h1B, 2'd0, 32'h05);
    chk(32'(dma_start), 32'h0, "R4 no start when already running");
    chk(32'(irq), 32'h1, "R7 irq raised");
    rd(6'h30, 2'd2, v); chk(v, 32'h0000_0140, "R7 global status bit 6");

    // R3: acknowledge, read-only bits, set beats clear
    wr(6'h16, 2'd0, 32'h04);
    chk(32'(irq), 32'h0, "R3 irq dropped after ack");
    eng_sts_set[5 +: 5] = 5'b00011;
    cycle();
    wr(6'h16, 2'd1, 32'h1F);
    rd(6'h16, 2'd1, v); chk(v, 32'h3, "R3 read-only bits kept");
    eng_sts_set[5 +: 5] = 5'b01000;
    wr(6'h16, 2'd0, 32'h08);
    rd(6'h16, 2'd1, v); chk(v, 32'hB, "R3 set wins over clear");
    wr(6'h16, 2'd0, 32'h08);
    rd(6'h16, 2'd1, v); chk(v, 32'h3, "R3 clear");

    // R7: FIFO error alone never interrupts; completion does (channel 0)
    eng_sts_set[0 +: 5] = 5'b10000;
    cycle();
    chk(32'(irq), 32'h0, "R7 fifo error no irq");
    eng_sts_set[0 +: 5] = 5'b01000;
    cycle();
    chk(32'(irq), 32'h1, "R7 completion irq");
    rd(6'h30, 2'd2, v); chk(v, 32'h0000_0120, "R7 global status bit 5");
    wr(6'h06, 2'd0, 32'h18);
    rd(6'h06, 2'd0, v); chk(v, 32'h1, "R3 clear both");
    chk(32'(irq), 32'h0, "R7 irq low");

    // R12: engine position update on channel 2
    eng_we = 1'b1; eng_ch = 2'd2; eng_cur = 5'd7; eng_pre = 5'd8; eng_cnt = 16'h1234;
    cycle();
    rd(6'h28, 2'd2, v); chk(v, 32'h0008_1234, "R12 count and prefetch");
    rd(6'h24, 2'd0, v); chk(v, 32'h7, "R12 current");

    // R9: global events and their acknowledge
    glb_evt = 4'hF;
    cycle();
    rd(6'h30, 2'd2, v); chk(v, 32'h0000_8D01, "R9 events set");
    wr(6'h30, 2'd2, 32'h0000_0801);
    rd(6'h30, 2'd2, v); chk(v, 32'h0000_8500, "R9 events cleared");

    // R4/R5: pulses on channel 2
    wr(6'h2B, 2'd0, 32'h01);
    chk(32'(dma_start), 32'h4, "R4 start pulse");
    rd(6'h24, 2'd0, v); chk(v, 32'h8, "R4 current from prefetch");
    rd(6'h2A, 2'd0, v); chk(v, 32'h9, "R4 prefetch advanced");
    wr(6'h2B, 2'd0, 32'h00);
    chk(32'(dma_stop), 32'h4, "R4 stop pulse");
    wr(6'h2B, 2'd0, 32'h02);
    chk(32'(dma_rst), 32'h4, "R5 reset pulse");
    rd(6'h28, 2'd2, v); chk(v, 32'h0, "R5 channel 2 cleared");

    done = 1;
    summary();
    $finish;
  end
endmodule